// File: doc/BRIEF.md
# Multi-Channel Phase-Offset PWM Generator

This block drives a bank of pulse-width-modulated outputs from one clock. Each channel has its own period, high-time and start offset, all counted in clock cycles. Within each period a channel's output goes high once the channel's counter reaches the offset, and stays high for the programmed high-time. The high pulse can therefore sit anywhere inside the period, so several outputs with one period can be staggered against each other.

Software programs the block through single-cycle register reads and writes. Channel writes land in shadow storage and have no effect on the outputs. A write to the load register moves every channel's shadow settings into its working registers on one clock edge and clears every channel counter on that same edge, so all channels start a new period together. A small controller state machine has two states, OFF and RUN. Reset puts it in OFF. The transition OFF→RUN ("start") fires on a control write with bit 0 set. The transition RUN→OFF ("stop") fires on a control write with bit 0 clear. In OFF every output is low and every counter is held at zero.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset, `pwm_out` is all zero, the controller is in OFF (control reads 0), and every channel register reads 0.
- R2: A read of address 0x00 returns 0x0002_0100, with the major version 2 in bits [23:16]. Writes to 0x00 are ignored.
- R3: Writes to a channel register (address 0x10 + 4·channel + slot, where slot 0 is period, slot 1 is high-time and slot 2 is offset) do not change any output until a later write to the load register at 0x02.
- R4: A write to 0x02 (any data) copies every channel's shadow registers into its working registers and sets every channel counter to 0 on the same clock edge. Channels with equal periods then stay phase-aligned.
- R5: While running, each counter advances by one per cycle and wraps to 0 after the value period−1. The output is high exactly when counter ≥ offset and counter − offset < high-time. A pulse that would run past the end of the period is cut off at the wrap.
- R6: A high-time greater than the period is treated as equal to the period. With offset 0 the output is then high for every cycle of the period.
- R7: If the offset is greater than or equal to the period, the output stays low for the whole period.
- R8: A period of 0 is treated as 1, and a high-time of 0 keeps the output low.
- R9: Writing bit 0 = 0 to the control register at 0x01 stops the generator. From the next cycle all outputs are low. Writing bit 0 = 1 starts it, and the counters begin from 0.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd`. A channel register read returns the shadow value, which is the last value written, zero-extended. Reads of the load register, of slot 3 and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The assertions assume that register programming happens only through one write per cycle, that a load write is never combined with another write in the same cycle, and that a channel counter only leaves its range through a load or a period change that a load brings in. The bench drives every access on the falling edge as a single-cycle strobe and issues one access at a time. It covers zero, oversize and out-of-range values through the same write path software would use. A behavioural model in the bench tracks shadows, working values, counters and the run state, and predicts every output on every cycle.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } gen_state_e;

    // Global register word addresses
    localparam int REG_VERSION = 0;
    localparam int REG_CTRL    = 1;
    localparam int REG_LOAD    = 2;

    // Channel window: base + 4*channel + slot
    localparam int CH_BASE     = 16;
    localparam int SLOT_PERIOD = 0;
    localparam int SLOT_DUTY   = 1;
    localparam int SLOT_OFFSET = 2;

    // Identification word: major [23:16], minor [15:8], patch [7:0]
    localparam logic [31:0] VERSION_WORD = 32'h0002_0100;

endpackage

// File: rtl/pwm_ctrl_fsm.sv
module pwm_ctrl_fsm
    import pwm_phase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       ctrl_val,
    output gen_state_e state_o,
    output logic       run_o
);

    gen_state_e state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (ctrl_wr && ctrl_val)  state_d = ST_RUN;   // start
            ST_RUN: if (ctrl_wr && !ctrl_val) state_d = ST_OFF;   // stop
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        state_o = state_q;
        run_o   = (state_q == ST_RUN);
    end

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_phase_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic                           run_i,
    output logic [NUM_CH-1:0][CNT_W-1:0]   shd_per,
    output logic [NUM_CH-1:0][CNT_W-1:0]   shd_duty,
    output logic [NUM_CH-1:0][CNT_W-1:0]   shd_off,
    output logic                           ctrl_wr,
    output logic                           ctrl_val,
    output logic                           load_o
);

    localparam int                IDX_W   = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(REG_VERSION);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(REG_LOAD);
    localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(CH_BASE);
    localparam logic [IDX_W-1:0]  N_CH    = IDX_W'(NUM_CH);

    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  ch_idx;
    logic [1:0]        slot;
    logic              in_ch;
    logic [DATA_W-1:0] rd_next;

    // address decode
    always_comb begin
        rel    = bus_addr - A_BASE;
        ch_idx = rel[ADDR_W-1:2];
        slot   = rel[1:0];
        in_ch  = (bus_addr >= A_BASE) && (ch_idx < N_CH) && (slot != 2'd3);
    end

    assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
    assign ctrl_val = bus_wdata[0];
    assign load_o   = bus_wr && (bus_addr == A_LOAD);

    // shadow storage, one bank per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_shadow
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(c);
        logic hit;
        assign hit = bus_wr && in_ch && (ch_idx == MY_IDX);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_per[c]  <= '0;
                shd_duty[c] <= '0;
                shd_off[c]  <= '0;
            end else if (hit) begin
                unique case (slot)
                    2'(SLOT_PERIOD): shd_per[c]  <= bus_wdata[CNT_W-1:0];
                    2'(SLOT_DUTY):   shd_duty[c] <= bus_wdata[CNT_W-1:0];
                    2'(SLOT_OFFSET): shd_off[c]  <= bus_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // read multiplexer
    always_comb begin
        rd_next = '0;
        if (bus_addr == A_VER) begin
            rd_next = DATA_W'(VERSION_WORD);
        end else if (bus_addr == A_CTRL) begin
            rd_next = DATA_W'(run_i);
        end else if (in_ch) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_idx == IDX_W'(c)) begin
                    unique case (slot)
                        2'(SLOT_PERIOD): rd_next = DATA_W'(shd_per[c]);
                        2'(SLOT_DUTY):   rd_next = DATA_W'(shd_duty[c]);
                        2'(SLOT_OFFSET): rd_next = DATA_W'(shd_off[c]);
                        default:         rd_next = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] shd_per,
    input  logic [CNT_W-1:0] shd_duty,
    input  logic [CNT_W-1:0] shd_off,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_per_o,
    output logic [CNT_W-1:0] act_duty_o,
    output logic [CNT_W-1:0] act_off_o,
    output logic             pwm_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, per_q, duty_q, off_q;
    logic [CNT_W-1:0] per_eff, duty_eff;
    logic             at_end, in_win;

    // effective limits
    always_comb begin
        per_eff  = (per_q == '0) ? ONE : per_q;
        duty_eff = (duty_q > per_eff) ? per_eff : duty_q;
        at_end   = (cnt_q >= per_eff - ONE);
        in_win   = (cnt_q >= off_q) && ((cnt_q - off_q) < duty_eff);
    end

    // working registers and period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
            off_q  <= '0;
        end else begin
            if (load) begin
                per_q  <= shd_per;
                duty_q <= shd_duty;
                off_q  <= shd_off;
                cnt_q  <= '0;
            end else if (run) begin
                cnt_q  <= at_end ? '0 : cnt_q + ONE;
            end else begin
                cnt_q  <= '0;
            end
        end
    end

    assign pwm_o      = run && in_win;
    assign cnt_o      = cnt_q;
    assign act_per_o  = per_q;
    assign act_duty_o = duty_q;
    assign act_off_o  = off_q;

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
    import pwm_phase_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0][CNT_W-1:0] shd_per, shd_duty, shd_off;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt, act_per, act_duty, act_off;
    logic                         ctrl_wr, ctrl_val, load, run;
    gen_state_e                   state;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .run_i     (run),
        .shd_per   (shd_per),
        .shd_duty  (shd_duty),
        .shd_off   (shd_off),
        .ctrl_wr   (ctrl_wr),
        .ctrl_val  (ctrl_val),
        .load_o    (load)
    );

    pwm_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_val (ctrl_val),
        .state_o  (state),
        .run_o    (run)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run),
            .load       (load),
            .shd_per    (shd_per[c]),
            .shd_duty   (shd_duty[c]),
            .shd_off    (shd_off[c]),
            .cnt_o      (cnt[c]),
            .act_per_o  (act_per[c]),
            .act_duty_o (act_duty[c]),
            .act_off_o  (act_off[c]),
            .pwm_o      (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk
    import pwm_phase_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_rd,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic                         run,
    input logic                         load,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_per,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_duty,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_off
);

    // R9
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_out == '0));

    // R4
    load_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '0));

    // R3
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_per) && $stable(act_duty) && $stable(act_off)));

    // R2
    version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(REG_VERSION)) |=> (bus_rdata == DATA_W'(VERSION_WORD)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        // R5
        cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_per[c] == '0) ? (cnt[c] == '0) : (cnt[c] < act_per[c]));

        // R7
        off_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_off[c] != '0 && act_off[c] >= act_per[c]) |-> !pwm_out[c]);

        // R8
        zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_duty[c] == '0) |-> !pwm_out[c]);

        // R6
        full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && act_off[c] == '0 && act_duty[c] != '0 && act_duty[c] >= act_per[c])
            |-> pwm_out[c]);
    end

endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .run       (run),
    .load      (load),
    .cnt       (cnt),
    .act_per   (act_per),
    .act_duty  (act_duty),
    .act_off   (act_off)
);

// File: tb/tb_pwm_phase_gen.sv
`timescale 1ns/1ps
module tb_pwm_phase_gen;

    localparam int NCH = 4;
    localparam int AW  = 8;
    localparam int DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    always #5 clk = ~clk;

    pwm_phase_gen #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    longint unsigned m_sp[NCH], m_sd[NCH], m_so[NCH];
    longint unsigned m_ap[NCH], m_ad[NCH], m_ao[NCH];
    longint unsigned m_cnt[NCH];
    bit              m_run;

    function automatic bit exp_out(int c);
        longint unsigned pe, de;
        pe = (m_ap[c] == 0) ? 1 : m_ap[c];
        de = (m_ad[c] > pe) ? pe : m_ad[c];
        return m_run && (m_cnt[c] >= m_ao[c]) && ((m_cnt[c] - m_ao[c]) < de);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_sp[c] = 0; m_sd[c] = 0; m_so[c] = 0;
                m_ap[c] = 0; m_ad[c] = 0; m_ao[c] = 0; m_cnt[c] = 0;
            end
            m_run = 1'b0;
        end else begin
            bit ld;
            ld = bus_wr && (bus_addr == 8'h02);
            for (int c = 0; c < NCH; c++) begin
                longint unsigned pe;
                pe = (m_ap[c] == 0) ? 1 : m_ap[c];
                if (ld)         m_cnt[c] = 0;
                else if (m_run) m_cnt[c] = (m_cnt[c] + 1 >= pe) ? 0 : m_cnt[c] + 1;
                else            m_cnt[c] = 0;
                if (ld) begin
                    m_ap[c] = m_sp[c]; m_ad[c] = m_sd[c]; m_ao[c] = m_so[c];
                end
            end
            if (bus_wr && bus_addr >= 8'h10 && bus_addr < 8'h10 + 4*NCH) begin
                int c, s;
                c = (int'(bus_addr) - 16) / 4;
                s = (int'(bus_addr) - 16) % 4;
                if (s == 0) m_sp[c] = bus_wdata;
                if (s == 1) m_sd[c] = bus_wdata;
                if (s == 2) m_so[c] = bus_wdata;
            end
            if (bus_wr && bus_addr == 8'h01) m_run = bus_wdata[0];
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            logic [NCH-1:0] e;
            for (int c = 0; c < NCH; c++) e[c] = exp_out(c);
            n_chk++;
            if (pwm_out !== e) begin
                n_bad++;
                $display("FAIL %s cycle %0d pwm_out actual=%b expected=%b", cur_req, cyc, pwm_out, e);
            end
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected<=20000", cyc);
            finish_up();
        end
    end

    task automatic wr(input int a, input longint unsigned d);
        bus_wr    = 1'b1;
        bus_addr  = AW'(a);
        bus_wdata = DW'(d);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input int a, input longint unsigned exp, input string req);
        bus_rd   = 1'b1;
        bus_addr = AW'(a);
        @(negedge clk);
        bus_rd   = 1'b0;
        n_chk++;
        if (bus_rdata !== DW'(exp)) begin
            n_bad++;
            $display("FAIL %s read 0x%0h actual=0x%0h expected=0x%0h", req, a, bus_rdata, DW'(exp));
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int ca(int c, int s);
        return 16 + 4*c + s;
    endfunction

    initial begin
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1: reset state
        cur_req = "R1";
        n_chk++;
        if (pwm_out !== '0) begin
            n_bad++;
            $display("FAIL R1 pwm_out actual=%b expected=0", pwm_out);
        end
        rd_chk(1, 0, "R1");
        rd_chk(ca(2, 1), 0, "R1");
        rd_chk(ca(3, 2), 0, "R1");

        // R2: version word, read-only
        rd_chk(0, 32'h0002_0100, "R2");
        wr(0, 32'hDEAD_BEEF);
        rd_chk(0, 32'h0002_0100, "R2");

        // R3: shadow writes and start, before any load
        cur_req = "R3";
        wr(ca(0, 0), 10); wr(ca(0, 1), 3); wr(ca(0, 2), 2);
        wr(ca(1, 0), 10); wr(ca(1, 1), 5); wr(ca(1, 2), 0);
        wr(ca(2, 0), 7);  wr(ca(2, 1), 9); wr(ca(2, 2), 0);   // R6 oversize high-time
        wr(ca(3, 0), 5);  wr(ca(3, 1), 2); wr(ca(3, 2), 5);   // R7 offset == period
        wr(1, 1);
        rd_chk(1, 1, "R9");
        idle(25);

        // R4 / R5: load and run
        cur_req = "R4";
        wr(2, 0);
        cur_req = "R5";
        idle(40);

        // R10: shadow readback; R3: new shadows do not reach outputs yet
        cur_req = "R3";
        wr(ca(0, 0), 6); wr(ca(0, 1), 6); wr(ca(0, 2), 1);    // pulse cut at wrap
        wr(ca(3, 2), 9);                                      // R7 offset > period
        rd_chk(ca(0, 0), 6, "R10");
        rd_chk(ca(0, 2), 1, "R10");
        rd_chk(ca(2, 1), 9, "R10");
        rd_chk(ca(0, 3), 0, "R10");
        rd_chk(2, 0, "R10");
        rd_chk(8'hF0, 0, "R10");
        idle(17);

        // R4: load in mid-period
        cur_req = "R4";
        wr(2, 0);
        cur_req = "R7";
        idle(30);

        // R8: zero period and zero high-time
        cur_req = "R8";
        wr(ca(1, 0), 0); wr(ca(1, 1), 1); wr(ca(1, 2), 0);
        wr(ca(2, 1), 0);
        wr(2, 0);
        idle(20);

        // R6: oversize high-time with offset 0
        cur_req = "R6";
        wr(ca(2, 0), 4); wr(ca(2, 1), 100);
        wr(2, 0);
        idle(12);

        // R9: stop and restart
        cur_req = "R9";
        wr(1, 0);
        n_chk++;
        if (pwm_out !== '0) begin
            n_bad++;
            $display("FAIL R9 pwm_out after stop actual=%b expected=0", pwm_out);
        end
        rd_chk(1, 0, "R9");
        wr(2, 0);                                             // load while stopped
        idle(8);
        wr(1, 1);
        idle(25);

        finish_up();
    end

endmodule